// File: doc/BRIEF.md
# Task Register Load Unit

This block performs the hardware side of loading the task register. A sequencer hands it a segment selector together with the descriptor already fetched for that selector: type code, base, limit, present flag and system flag. The block checks the descriptor in one cycle. It then either reports a fault with a two-bit code and the selector index, or goes on to a short sequence of memory accesses. On the success path it reads the I/O permission map offset out of a 32-bit task segment. It then sets the busy bit in the descriptor's upper dword by reading and writing that dword. Finally it commits the new task register state and the I/O permission window in a single cycle.

The block does not walk descriptor tables and does not deliver faults. It reports the outcome through one-cycle pulses: `done_o` for a commit, `fault_o` for a rejected descriptor, and `err_o` when it finds that the descriptor is already busy. Memory traffic uses a request/ready handshake, one dword per transfer.

Top module: `tr_load_unit`

## Requirements
- R1: A general-protection fault (code 1) is raised if the selector's table-indicator bit (bit 2) is set, if the system flag is low, or if the type code is neither 4'h1 (16-bit available) nor 4'h9 (32-bit available). The fault index is always selector bits [15:3].
- R2: An invalid-task-segment fault (code 2) is raised when a 16-bit segment has a limit below 43 or a 32-bit segment has a limit below 103. Limits of exactly 43 and 103 are accepted.
- R3: A not-present fault (code 3) is raised only when the type and limit checks pass. A descriptor that is both too short and not present reports code 2.
- R4: A fault pulses `fault_o` for one cycle, in the second cycle after the start cycle. It makes no memory access and leaves every task register output unchanged.
- R5: For a 32-bit segment the block reads the dword at base+100 and takes bits [31:16] as the I/O map base. For a 16-bit segment it makes no such read and uses an I/O base of 0.
- R6: The busy update reads the dword at table base + (selector with bits [2:0] cleared) + 4. It writes the same dword back with bit 9 set.
- R7: If bit 9 of that dword is already set, the block pulses `err_o`. It makes no write and does not commit.
- R8: On commit, `done_o` pulses and the outputs take the following values: `tr_sel_o` is the selector, `tr_type_o` is the type with bit 1 set, and `tr_base_o` and `tr_limit_o` are the descriptor's base and limit.
- R9: On commit the I/O limit becomes 0, unless the segment is a 32-bit one whose I/O base is below its limit. In that case the I/O limit becomes (limit − iobase) truncated to 16 bits, and the I/O address becomes base + iobase. When the window is not opened, the I/O address keeps its previous value.
- R10: `busy_o` is high from the cycle after a start until the cycle in which the result pulse appears. A start that arrives while `busy_o` is high is ignored.
- R11: Once raised, a memory request holds its address, write enable and write data until the cycle in which ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load when idle |
| sel_i | input | 16 | Task segment selector |
| desc_type_i | input | 4 | Descriptor type code |
| desc_base_i | input | 32 | Descriptor base address |
| desc_limit_i | input | 32 | Descriptor byte limit |
| desc_present_i | input | 1 | Descriptor present flag |
| desc_sys_i | input | 1 | High for a system descriptor |
| tbl_base_i | input | 32 | Global descriptor table base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | High for a write |
| mem_addr_o | output | 32 | Byte address of the dword |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Transfer completes this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Commit pulse |
| fault_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | 1 general protection, 2 invalid task segment, 3 not present |
| fault_idx_o | output | 13 | Selector index of the fault |
| err_o | output | 1 | Descriptor already busy |
| tr_sel_o | output | 16 | Committed selector |
| tr_type_o | output | 4 | Committed type, busy bit set |
| tr_base_o | output | 32 | Committed base |
| tr_limit_o | output | 32 | Committed limit |
| io_limit_o | output | 16 | I/O permission window length |
| io_addr_o | output | 32 | I/O permission map address |

## Verification
The assertions check several properties on every cycle. A pending memory request must hold its address and direction. Every write must carry the busy bit. A commit must directly follow a completed write. A fault must leave the task register untouched. A non-zero I/O window may only ever appear for a busy 32-bit type. Other behaviours can only be shown by the bench's scenarios. These are the priority between fault causes at the 43/103 limit boundaries, the exact memory word left behind after the busy update, and the count of accesses made on each path. The same holds for the window arithmetic at iobase = limit − 1 and iobase ≥ limit, and for the already-busy abort.

// File: rtl/tr_load_pkg.sv
package tr_load_pkg;
   localparam logic [3:0] T16_AVAIL = 4'h1;
   localparam logic [3:0] T32_AVAIL = 4'h9;
   localparam logic [3:0] BUSY_IND  = 4'h2;
   localparam logic [3:0] T32_BUSY  = T32_AVAIL | BUSY_IND;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_GP   = 2'd1,
      FC_TS   = 2'd2,
      FC_NP   = 2'd3
   } fault_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHK,
      ST_IORD,
      ST_DRD,
      ST_DWR
   } tr_state_e;
endpackage

// File: rtl/tr_desc_check.sv
module tr_desc_check
   import tr_load_pkg::*;
#(
   parameter int LIMW     = 32,
   parameter int MIN16    = 43,
   parameter int MIN32    = 103
) (
   input  logic [3:0]      type_i,
   input  logic [LIMW-1:0] limit_i,
   input  logic            present_i,
   input  logic            sys_i,
   input  logic            local_i,
   output fault_code_e     code_o,
   output logic            is32_o
);
   localparam logic [LIMW-1:0] LIM16 = LIMW'(MIN16);
   localparam logic [LIMW-1:0] LIM32 = LIMW'(MIN32);

   logic kind_ok, short_seg;

   always_comb begin
      is32_o    = (type_i == T32_AVAIL);
      kind_ok   = sys_i && !local_i && (type_i == T16_AVAIL || type_i == T32_AVAIL);
      short_seg = is32_o ? (limit_i < LIM32) : (limit_i < LIM16);
      if (!kind_ok)
         code_o = FC_GP;
      else if (short_seg)
         code_o = FC_TS;
      else if (!present_i)
         code_o = FC_NP;
      else
         code_o = FC_NONE;
   end
endmodule

// File: rtl/tr_io_window.sv
module tr_io_window
   import tr_load_pkg::*;
#(
   parameter int AW   = 32,
   parameter int LIMW = 32,
   parameter int IOW  = 16
) (
   input  logic            is32_i,
   input  logic [AW-1:0]   base_i,
   input  logic [LIMW-1:0] limit_i,
   input  logic [IOW-1:0]  iobase_i,
   output logic            open_o,
   output logic [IOW-1:0]  len_o,
   output logic [AW-1:0]   addr_o
);
   logic [LIMW-1:0] iob_ext;
   logic [LIMW-1:0] diff;

   always_comb begin
      iob_ext = LIMW'(iobase_i);
      diff    = limit_i - iob_ext;
      open_o  = is32_i && (iob_ext < limit_i);
      len_o   = open_o ? diff[IOW-1:0] : '0;
      addr_o  = base_i + AW'(iobase_i);
   end
endmodule

// File: rtl/tr_load_unit.sv
module tr_load_unit
   import tr_load_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LIMW      = 32,
   parameter int SELW      = 16,
   parameter int IOW       = 16,
   parameter int BUSY_BIT  = 9,
   parameter int MIN16     = 43,
   parameter int MIN32     = 103,
   parameter int IOMAP_OFS = 102
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SELW-1:0]  sel_i,
   input  logic [3:0]       desc_type_i,
   input  logic [AW-1:0]    desc_base_i,
   input  logic [LIMW-1:0]  desc_limit_i,
   input  logic             desc_present_i,
   input  logic             desc_sys_i,
   input  logic [AW-1:0]    tbl_base_i,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [AW-1:0]    mem_addr_o,
   output logic [DW-1:0]    mem_wdata_o,
   input  logic [DW-1:0]    mem_rdata_i,
   input  logic             mem_ready_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             fault_o,
   output logic [1:0]       fault_code_o,
   output logic [SELW-4:0]  fault_idx_o,
   output logic             err_o,
   output logic [SELW-1:0]  tr_sel_o,
   output logic [3:0]       tr_type_o,
   output logic [AW-1:0]    tr_base_o,
   output logic [LIMW-1:0]  tr_limit_o,
   output logic [IOW-1:0]   io_limit_o,
   output logic [AW-1:0]    io_addr_o
);
   localparam int          HI_OFS    = 4;
   localparam logic [AW-1:0] IODW_OFS = AW'(IOMAP_OFS & ~3);
   localparam int          IO_LANE   = (IOMAP_OFS % 4) / 2;
   localparam logic [DW-1:0] BUSY_MSK = DW'(1) << BUSY_BIT;

   if (DW != 32) begin : g_bad_dw
      $error("tr_load_unit: DW must be 32");
   end
   if (BUSY_BIT >= DW) begin : g_bad_busy
      $error("tr_load_unit: BUSY_BIT out of range");
   end
   if (IOW != 16 || (IOMAP_OFS % 2) != 0) begin : g_bad_io
      $error("tr_load_unit: I/O base must be an aligned 16-bit field");
   end

   tr_state_e         st;
   logic [SELW-1:0]   l_sel;
   logic [3:0]        l_type;
   logic [AW-1:0]     l_base;
   logic [LIMW-1:0]   l_limit;
   logic              l_present, l_sys;
   logic [IOW-1:0]    iob_q;
   logic [DW-1:0]     hi_q;
   logic [AW-1:0]     desc_hi_addr;

   fault_code_e       chk_code;
   logic              chk_is32;
   logic [IOW-1:0]    io_half;
   logic              win_open;
   logic [IOW-1:0]    win_len;
   logic [AW-1:0]     win_addr;

   tr_desc_check #(.LIMW(LIMW), .MIN16(MIN16), .MIN32(MIN32)) u_check (
      .type_i    (l_type),
      .limit_i   (l_limit),
      .present_i (l_present),
      .sys_i     (l_sys),
      .local_i   (l_sel[2]),
      .code_o    (chk_code),
      .is32_o    (chk_is32)
   );

   tr_io_window #(.AW(AW), .LIMW(LIMW), .IOW(IOW)) u_win (
      .is32_i   ((l_type | BUSY_IND) == T32_BUSY),
      .base_i   (l_base),
      .limit_i  (l_limit),
      .iobase_i (iob_q),
      .open_o   (win_open),
      .len_o    (win_len),
      .addr_o   (win_addr)
   );

   if (IO_LANE == 1) begin : g_io_hi
      assign io_half = mem_rdata_i[DW-1 -: IOW];
   end else begin : g_io_lo
      assign io_half = mem_rdata_i[IOW-1:0];
   end

   always_comb begin
      desc_hi_addr = tbl_base_i + AW'({l_sel[SELW-1:3], 3'b000}) + AW'(HI_OFS);
      mem_req_o    = (st == ST_IORD) || (st == ST_DRD) || (st == ST_DWR);
      mem_we_o     = (st == ST_DWR);
      mem_wdata_o  = hi_q;
      unique case (st)
         ST_IORD: mem_addr_o = l_base + IODW_OFS;
         ST_DRD,
         ST_DWR:  mem_addr_o = desc_hi_addr;
         default: mem_addr_o = '0;
      endcase
      busy_o = (st != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         l_sel        <= '0;
         l_type       <= '0;
         l_base       <= '0;
         l_limit      <= '0;
         l_present    <= 1'b0;
         l_sys        <= 1'b0;
         iob_q        <= '0;
         hi_q         <= '0;
         done_o       <= 1'b0;
         fault_o      <= 1'b0;
         err_o        <= 1'b0;
         fault_code_o <= '0;
         fault_idx_o  <= '0;
         tr_sel_o     <= '0;
         tr_type_o    <= '0;
         tr_base_o    <= '0;
         tr_limit_o   <= '0;
         io_limit_o   <= '0;
         io_addr_o    <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         err_o   <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  l_sel     <= sel_i;
                  l_type    <= desc_type_i;
                  l_base    <= desc_base_i;
                  l_limit   <= desc_limit_i;
                  l_present <= desc_present_i;
                  l_sys     <= desc_sys_i;
                  st        <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (chk_code != FC_NONE) begin
                  fault_o      <= 1'b1;
                  fault_code_o <= chk_code;
                  fault_idx_o  <= l_sel[SELW-1:3];
                  st           <= ST_IDLE;
               end else if (chk_is32) begin
                  st <= ST_IORD;
               end else begin
                  iob_q <= '0;
                  st    <= ST_DRD;
               end
            end
            ST_IORD: begin
               if (mem_ready_i) begin
                  iob_q <= io_half;
                  st    <= ST_DRD;
               end
            end
            ST_DRD: begin
               if (mem_ready_i) begin
                  if (mem_rdata_i[BUSY_BIT]) begin
                     err_o <= 1'b1;
                     st    <= ST_IDLE;
                  end else begin
                     hi_q <= mem_rdata_i | BUSY_MSK;
                     st   <= ST_DWR;
                  end
               end
            end
            ST_DWR: begin
               if (mem_ready_i) begin
                  tr_sel_o   <= l_sel;
                  tr_type_o  <= l_type | BUSY_IND;
                  tr_base_o  <= l_base;
                  tr_limit_o <= l_limit;
                  io_limit_o <= win_len;
                  if (win_open)
                     io_addr_o <= win_addr;
                  done_o <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R6
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> mem_wdata_o[BUSY_BIT]);

   // R8
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));

   // R4
   fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> ($stable(tr_sel_o) && $stable(tr_type_o) && !done_o && !$past(mem_req_o)));

   // R9
   io_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_limit_o != '0) |-> (tr_type_o == T32_BUSY));

   // R10
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({done_o, fault_o, err_o}) <= 1);
endmodule

// File: tb/tb_tr_load_unit.sv
`timescale 1ns/1ps
module tb_tr_load_unit;
   localparam logic [31:0] TBL = 32'h0001_0000;

   typedef struct {
      int          kind;     // 0 done, 1 fault, 2 err
      logic [1:0]  code;
      logic [12:0] idx;
      logic [15:0] sel;
      logic [3:0]  typ;
      logic [31:0] base;
      logic [31:0] lim;
      logic [15:0] iolim;
      logic [31:0] ioaddr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] sel_i = '0;
   logic [3:0]  desc_type_i = '0;
   logic [31:0] desc_base_i = '0;
   logic [31:0] desc_limit_i = '0;
   logic        desc_present_i = 1'b0;
   logic        desc_sys_i = 1'b0;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_ready_i = 1'b0;
   logic        busy_o, done_o, fault_o, err_o;
   logic [1:0]  fault_code_o;
   logic [12:0] fault_idx_o;
   logic [15:0] tr_sel_o;
   logic [3:0]  tr_type_o;
   logic [31:0] tr_base_o, tr_limit_o;
   logic [15:0] io_limit_o;
   logic [31:0] io_addr_o;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int lat_cnt = 0;
   int n_acc = 0;
   logic [31:0] mem [logic [31:0]];
   exp_t q[$];
   exp_t model;

   always #2.5 clk = ~clk;

   tr_load_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
      .desc_type_i(desc_type_i), .desc_base_i(desc_base_i),
      .desc_limit_i(desc_limit_i), .desc_present_i(desc_present_i),
      .desc_sys_i(desc_sys_i), .tbl_base_i(TBL),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ready_i(mem_ready_i), .busy_o(busy_o), .done_o(done_o),
      .fault_o(fault_o), .fault_code_o(fault_code_o),
      .fault_idx_o(fault_idx_o), .err_o(err_o), .tr_sel_o(tr_sel_o),
      .tr_type_o(tr_type_o), .tr_base_o(tr_base_o),
      .tr_limit_o(tr_limit_o), .io_limit_o(io_limit_o),
      .io_addr_o(io_addr_o)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // memory responder with programmable latency
   always @(posedge clk) begin
      mem_ready_i <= 1'b0;
      if (mem_req_o && !mem_ready_i) begin
         if (lat_cnt >= lat) begin
            lat_cnt     <= 0;
            mem_ready_i <= 1'b1;
            mem_rdata_i <= rd(mem_addr_o);
            n_acc       <= n_acc + 1;
            if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // monitor: pop and compare
   always @(negedge clk) begin
      if (rst_n && (done_o || fault_o || err_o)) begin
         if (q.size() == 0) begin
            check(1'b0, "unexpected result pulse", 1, 0);
         end else begin
            exp_t e;
            int   k;
            e = q.pop_front();
            k = done_o ? 0 : (fault_o ? 1 : 2);
            check(k == e.kind, {e.tag, " result kind"}, 64'(k), 64'(e.kind));
            if (e.kind == 1) begin
               check(fault_code_o == e.code, {e.tag, " fault code"}, 64'(fault_code_o), 64'(e.code));
               check(fault_idx_o == e.idx, {e.tag, " fault index"}, 64'(fault_idx_o), 64'(e.idx));
            end
            check(tr_sel_o == e.sel && tr_type_o == e.typ, {e.tag, " R8 sel/type"},
                  {44'd0, tr_sel_o, tr_type_o}, {44'd0, e.sel, e.typ});
            check(tr_base_o == e.base && tr_limit_o == e.lim, {e.tag, " R8 base/limit"},
                  {tr_base_o, tr_limit_o}, {e.base, e.lim});
            check(io_limit_o == e.iolim && io_addr_o == e.ioaddr, {e.tag, " R9 io window"},
                  {16'd0, io_limit_o, io_addr_o}, {16'd0, e.iolim, e.ioaddr});
         end
      end
   end

   task automatic run_op(input string tag, input logic [15:0] sel, input logic [3:0] typ,
                         input logic [31:0] base, input logic [31:0] lim,
                         input bit pres, input bit sys, input int latency);
      exp_t e;
      logic [31:0] da, hi, iow;
      logic [15:0] iob;
      int exp_acc;
      e = model;
      e.tag = tag;
      e.code = 2'd0;
      e.idx = sel[15:3];
      if (sel[2] || !sys || (typ != 4'h1 && typ != 4'h9)) e.code = 2'd1;        // R1
      else if ((typ == 4'h1 && lim < 43) || (typ == 4'h9 && lim < 103)) e.code = 2'd2; // R2
      else if (!pres) e.code = 2'd3;                                            // R3
      da = TBL + {16'd0, sel[15:3], 3'b000} + 32'd4;                            // R6
      hi = rd(da);
      exp_acc = 0;
      if (e.code != 2'd0) begin
         e.kind = 1;
      end else if (hi[9]) begin                                                 // R7
         e.kind = 2;
         exp_acc = (typ == 4'h9) ? 2 : 1;
      end else begin
         e.kind = 0;
         exp_acc = (typ == 4'h9) ? 3 : 2;
         iow = rd(base + 32'd100);
         iob = (typ == 4'h9) ? iow[31:16] : 16'd0;                              // R5
         e.sel = sel; e.typ = typ | 4'h2; e.base = base; e.lim = lim;
         if (typ == 4'h9 && {16'd0, iob} < lim) begin
            e.iolim = 16'(lim - {16'd0, iob});
            e.ioaddr = base + {16'd0, iob};
         end else begin
            e.iolim = 16'd0;
         end
      end
      q.push_back(e);
      lat = latency;
      n_acc = 0;
      @(negedge clk);
      sel_i = sel; desc_type_i = typ; desc_base_i = base; desc_limit_i = lim;
      desc_present_i = pres; desc_sys_i = sys; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, {tag, " R10 busy after start"}, 64'(busy_o), 1);
      while (busy_o) begin
         @(negedge clk);
         // R10: a second start while busy must be ignored
         start_i = 1'b1;
      end
      start_i = 1'b0;
      @(negedge clk);
      check(q.size() == 0, {tag, " R10 result seen"}, 64'(q.size()), 0);
      check(n_acc == exp_acc, {tag, " R4/R5 access count"}, 64'(n_acc), 64'(exp_acc));
      if (e.kind == 0)
         check(rd(da) == (hi | 32'h200), {tag, " R6 busy written"}, 64'(rd(da)), 64'(hi | 32'h200));
      else
         check(rd(da) == hi, {tag, " R4/R7 descriptor untouched"}, 64'(rd(da)), 64'(hi));
      model = e;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model = '{kind: 0, code: 2'd0, idx: '0, sel: '0, typ: '0, base: '0,
                lim: '0, iolim: '0, ioaddr: '0, tag: ""};
      // descriptor upper dwords, busy bit clear
      mem[TBL + 32'h08 + 4] = 32'h0000_8900;
      mem[TBL + 32'h10 + 4] = 32'h0000_8100;
      mem[TBL + 32'h18 + 4] = 32'h0000_8900;
      mem[TBL + 32'h20 + 4] = 32'h0000_8B00;   // already busy
      mem[TBL + 32'h28 + 4] = 32'h0000_8900;
      mem[TBL + 32'h30 + 4] = 32'h0000_8900;
      mem[TBL + 32'h38 + 4] = 32'h0000_8100;
      // I/O base words (upper half of dword at base+100)
      mem[32'h0002_0000 + 100] = 32'h0068_0000;
      mem[32'h0003_0000 + 100] = 32'h0200_0000;
      mem[32'h0004_0000 + 100] = 32'h00FF_0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && !fault_o && !err_o, "reset outputs idle", 64'(busy_o), 0);
      check(tr_sel_o == 0 && io_limit_o == 0 && !mem_req_o, "reset state cleared", 64'(tr_sel_o), 0);

      run_op("R1 local table",   16'h000C, 4'h9, 32'h0002_0000, 32'd200, 1, 1, 0);
      run_op("R1 not system",    16'h0008, 4'h9, 32'h0002_0000, 32'd200, 1, 0, 0);
      run_op("R1 busy type",     16'h0008, 4'hB, 32'h0002_0000, 32'd200, 1, 1, 0);
      run_op("R2 short 16",      16'h0010, 4'h1, 32'h0005_0000, 32'd42,  1, 1, 0);
      run_op("R2 short 32",      16'h0008, 4'h9, 32'h0002_0000, 32'd102, 1, 1, 0);
      run_op("R3 short and absent", 16'h0008, 4'h9, 32'h0002_0000, 32'd102, 0, 1, 0);
      run_op("R3 absent",        16'h0008, 4'h9, 32'h0002_0000, 32'd200, 0, 1, 0);
      run_op("R5 R9 load 32",    16'h0008, 4'h9, 32'h0002_0000, 32'h100, 1, 1, 2);
      run_op("R5 load 16 min",   16'h0010, 4'h1, 32'h0005_0000, 32'd43,  1, 1, 1);
      run_op("R7 already busy",  16'h0020, 4'h9, 32'h0002_0000, 32'd200, 1, 1, 0);
      run_op("R9 base above limit", 16'h0018, 4'h9, 32'h0003_0000, 32'h150, 1, 1, 3);
      run_op("R9 base limit-1",  16'h0028, 4'h9, 32'h0004_0000, 32'h100, 1, 1, 0);
      run_op("R2 32 min limit",  16'h0030, 4'h9, 32'h0003_0000, 32'd103, 1, 1, 1);
      run_op("R8 16 after 32",   16'h0038, 4'h1, 32'h0006_0000, 32'h300, 1, 1, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule